// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block sits beside a CPU pipeline and watches two streams every cycle: the address of the instruction being fetched, and the address, size and direction of any data access. It holds four slot address registers, a status register and a control register. Each slot is configured through its control fields to watch for execution at one address, for writes to a small aligned region, or for reads and writes to that region.

On every cycle the unit works out which slots match the current inputs. If a matching slot is enabled, it updates the status register and raises a debug-exception pulse one cycle later. When a slot matches but is disabled, its hit is still recorded, but only if some other cause commits the status in the same cycle. Other cycles leave the status untouched. A single-step event always commits the status and marks it as a step. A task-switch event disarms all slots that were armed only locally.

Software reaches the registers through one indexed port. Indices 0 to 3 select the slot addresses. Index 6 is the status register and index 7 is the control register. Indices 4 and 5 mirror 6 and 7.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset the slot addresses read 0, status reads 0xFFFF0FF0 and control reads 0x00000400.
- R2: Read index 0–3 returns slot address i; indices 4 and 6 return status; 5 and 7 return control. Writes to status are ORed with 0xFFFF0FF0. Writes to control are ORed with 0x00000400.
- R3: Slot i is enabled when control bit 2i (local) or 2i+1 (global) is set. An enabled match causes `dbg_exc_o` to be high for exactly the cycle after the inputs were presented.
- R4: The type of slot i is control bits [17+2i:16+2i]. Type 00 matches when the fetch is valid and the fetch address equals the slot address exactly.
- R5: Type 01 matches valid data writes only. Type 11 matches both reads and writes. Type 10 never matches.
- R6: The length code of slot i is control bits [19+2i:18+2i], with 00=1, 01=2, 10=8 and 11=4 bytes. The watched region starts at the slot address with its low bits cleared to that length. A data slot matches when the access bytes overlap the region. The access size code is 00=1, 01=2, 10=4 and 11=8 bytes.
- R7: A match on a disabled slot raises no exception and, without a forced update, leaves the status register unchanged.
- R8: A status commit replaces status bits 3:0 with the match vector of all slots, enabled or not, and keeps the other bits. A commit takes priority over a software status write in the same cycle.
- R9: `step_i` forces a status commit and sets status bit 14. By itself it raises no exception.
- R10: `task_sw_i` clears control bits 0, 2, 4 and 6, which disarms slots that were only locally enabled. A software control write in the same cycle takes priority.
- R11: A register write is used for matching from the next cycle. An access in the same cycle as the write is matched against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register index 0–7 |
| reg_wdata_i | input | XLEN | Write data |
| reg_rdata_o | output | XLEN | Read data for reg_idx_i (combinational) |
| if_valid_i | input | 1 | Fetch address valid |
| if_addr_i | input | XLEN | Fetch address |
| da_valid_i | input | 1 | Data access valid |
| da_addr_i | input | XLEN | Data access start address |
| da_size_i | input | 2 | Access size code |
| da_write_i | input | 1 | 1 = write, 0 = read |
| step_i | input | 1 | Single-step event |
| task_sw_i | input | 1 | Task-switch event |
| dbg_exc_o | output | 1 | Debug-exception pulse |

## Verification
The bench builds the unit with its defaults: XLEN of 32 and four slots. This puts every control field position and the exact reset constants within reach of direct checks. With 32-bit addresses, the bench can place regions and accesses whose byte ranges overlap by a single byte at either edge. It can also probe the 8-byte length code and the 4-byte access size against each other, and run two slots matching the same fetch so that enabled and disabled hits meet in one status commit.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    BP_EXEC = 2'b00,
    BP_WR   = 2'b01,
    BP_IO   = 2'b10,
    BP_RW   = 2'b11
  } bp_type_e;

  localparam logic [31:0] STAT_FIXED = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_FIXED = 32'h0000_0400;
  localparam logic [31:0] LOCAL_MASK = 32'h0000_0055;
  localparam int STEP_BIT = 14;
  localparam int TYPE_LSB = 16;
  localparam int LEN_LSB  = 18;

  // non-linear length code
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   len_bytes = 4'd1;
      2'b01:   len_bytes = 4'd2;
      2'b10:   len_bytes = 4'd8;
      default: len_bytes = 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] acc_bytes(input logic [1:0] code);
    acc_bytes = 4'd1 << code;
  endfunction
endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
  import dbg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] slot_addr_i,
  input  bp_type_e        type_i,
  input  logic [1:0]      len_i,
  input  logic            if_valid_i,
  input  logic [XLEN-1:0] if_addr_i,
  input  logic            da_valid_i,
  input  logic [XLEN-1:0] da_addr_i,
  input  logic [1:0]      da_size_i,
  input  logic            da_write_i,
  output logic            match_o
);
  logic [3:0]    reg_len;
  logic [3:0]    acc_len;
  logic [XLEN:0] reg_lo, reg_hi, acc_lo, acc_hi;
  logic          data_ovl;

  always_comb begin
    reg_len  = len_bytes(len_i);
    acc_len  = acc_bytes(da_size_i);
    // extra msb keeps range ends from wrapping
    reg_lo   = {1'b0, slot_addr_i & ~(XLEN'(reg_len) - XLEN'(1))};
    reg_hi   = reg_lo + (XLEN+1)'(reg_len) - (XLEN+1)'(1);
    acc_lo   = {1'b0, da_addr_i};
    acc_hi   = acc_lo + (XLEN+1)'(acc_len) - (XLEN+1)'(1);
    data_ovl = da_valid_i && (acc_lo <= reg_hi) && (reg_lo <= acc_hi);
  end

  always_comb begin
    case (type_i)
      BP_EXEC: match_o = if_valid_i && (if_addr_i == slot_addr_i);
      BP_WR:   match_o = data_ovl && da_write_i;
      BP_RW:   match_o = data_ovl;
      default: match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
  import dbg_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int N_SLOTS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [2:0]                    reg_idx_i,
  input  logic [XLEN-1:0]               reg_wdata_i,
  output logic [XLEN-1:0]               reg_rdata_o,
  input  logic                          commit_i,
  input  logic [XLEN-1:0]               commit_stat_i,
  input  logic                          task_sw_i,
  output logic [N_SLOTS-1:0][XLEN-1:0]  slot_addr_o,
  output logic [XLEN-1:0]               stat_o,
  output logic [XLEN-1:0]               ctrl_o
);
  logic [XLEN-1:0] stat_q, ctrl_q;
  logic            stat_wr, ctrl_wr;

  assign stat_wr = reg_we_i && (reg_idx_i == 3'd4 || reg_idx_i == 3'd6);
  assign ctrl_wr = reg_we_i && (reg_idx_i == 3'd5 || reg_idx_i == 3'd7);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_addr_o[i] <= '0;
      else if (reg_we_i && reg_idx_i == 3'(i))       slot_addr_o[i] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= XLEN'(STAT_FIXED);
    else if (commit_i) stat_q <= commit_stat_i;
    else if (stat_wr)  stat_q <= reg_wdata_i | XLEN'(STAT_FIXED);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= XLEN'(CTRL_FIXED);
    else if (ctrl_wr)   ctrl_q <= reg_wdata_i | XLEN'(CTRL_FIXED);
    else if (task_sw_i) ctrl_q <= ctrl_q & ~XLEN'(LOCAL_MASK);
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      3'd4, 3'd6: reg_rdata_o = stat_q;
      3'd5, 3'd7: reg_rdata_o = ctrl_q;
      default: begin
        for (int i = 0; i < N_SLOTS; i++)
          if (reg_idx_i == 3'(i)) reg_rdata_o = slot_addr_o[i];
      end
    endcase
  end

  assign stat_o = stat_q;
  assign ctrl_o = ctrl_q;

  // R2
  fixed_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & XLEN'(STAT_FIXED)) == XLEN'(STAT_FIXED)) && ctrl_q[10]);

  // R10
  local_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_sw_i && !ctrl_wr) |=> ((ctrl_q & XLEN'(LOCAL_MASK)) == '0));
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int N_SLOTS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_idx_i,
  input  logic [XLEN-1:0] reg_wdata_i,
  output logic [XLEN-1:0] reg_rdata_o,
  input  logic            if_valid_i,
  input  logic [XLEN-1:0] if_addr_i,
  input  logic            da_valid_i,
  input  logic [XLEN-1:0] da_addr_i,
  input  logic [1:0]      da_size_i,
  input  logic            da_write_i,
  input  logic            step_i,
  input  logic            task_sw_i,
  output logic            dbg_exc_o
);
  localparam int EN_W = 2 * N_SLOTS;

  logic [N_SLOTS-1:0][XLEN-1:0] slot_addr;
  logic [XLEN-1:0]              stat, ctrl, new_stat;
  logic [N_SLOTS-1:0]           hit, slot_en;
  logic                         hit_en, commit, exc_q;

  dbg_reg_file #(.XLEN(XLEN), .N_SLOTS(N_SLOTS)) i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_idx_i, .reg_wdata_i, .reg_rdata_o,
    .commit_i(commit), .commit_stat_i(new_stat), .task_sw_i,
    .slot_addr_o(slot_addr), .stat_o(stat), .ctrl_o(ctrl)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign slot_en[i] = |ctrl[2*i +: 2];
    dbg_slot_match #(.XLEN(XLEN)) i_match (
      .slot_addr_i(slot_addr[i]),
      .type_i     (bp_type_e'(ctrl[TYPE_LSB + 2*i +: 2])),
      .len_i      (ctrl[LEN_LSB + 2*i +: 2]),
      .if_valid_i, .if_addr_i, .da_valid_i, .da_addr_i, .da_size_i, .da_write_i,
      .match_o    (hit[i])
    );
  end

  always_comb begin
    hit_en   = |(hit & slot_en);
    commit   = hit_en || step_i;
    new_stat = stat;
    new_stat[N_SLOTS-1:0] = hit;
    if (step_i) new_stat[STEP_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exc_q <= 1'b0;
    else         exc_q <= hit_en;
  end

  assign dbg_exc_o = exc_q;

  // R8
  exc_has_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_o |-> (stat[N_SLOTS-1:0] != '0));

  // R3
  exc_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_en |=> ($past(ctrl[EN_W-1:0]) != '0) && dbg_exc_o);

  // R9
  step_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> stat[STEP_BIT]);

  // R7
  no_enable_no_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[EN_W-1:0] == '0) |=> !dbg_exc_o);
endmodule

// File: tb/test_dbg_match_unit.sv
`timescale 1ns/1ps
module test_dbg_match_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        if_valid_i = 1'b0;
  logic [31:0] if_addr_i = '0;
  logic        da_valid_i = 1'b0;
  logic [31:0] da_addr_i = '0;
  logic [1:0]  da_size_i = '0;
  logic        da_write_i = 1'b0;
  logic        step_i = 1'b0;
  logic        task_sw_i = 1'b0;
  logic        dbg_exc_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  dbg_match_unit i_dbg_match_unit (.*);

  typedef struct packed {
    logic [31:0] ctrl; logic [31:0] addr;
    logic iv; logic [31:0] ia;
    logic dv; logic [31:0] da; logic [1:0] ds; logic dw;
    logic exc; logic [3:0] st;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0001, 32'h1000, 1'b1, 32'h1000, 1'b0, 32'h0,    2'd0, 1'b0, 1'b1, 4'h1},
    '{32'h0000_0001, 32'h1000, 1'b1, 32'h1001, 1'b0, 32'h0,    2'd0, 1'b0, 1'b0, 4'h0},
    '{32'h000D_0001, 32'h2002, 1'b0, 32'h0,    1'b1, 32'h2003, 2'd0, 1'b1, 1'b1, 4'h1},
    '{32'h000D_0001, 32'h2002, 1'b0, 32'h0,    1'b1, 32'h2003, 2'd0, 1'b0, 1'b0, 4'h0},
    '{32'h000B_0001, 32'h3000, 1'b0, 32'h0,    1'b1, 32'h3007, 2'd0, 1'b0, 1'b1, 4'h1},
    '{32'h000B_0001, 32'h3000, 1'b0, 32'h0,    1'b1, 32'h2FFE, 2'd2, 1'b0, 1'b1, 4'h1},
    '{32'h000B_0001, 32'h3000, 1'b0, 32'h0,    1'b1, 32'h2FFC, 2'd2, 1'b1, 1'b0, 4'h0},
    '{32'h0002_0001, 32'h4000, 1'b0, 32'h0,    1'b1, 32'h4000, 2'd0, 1'b1, 1'b0, 4'h0},
    '{32'h0005_0001, 32'h5001, 1'b0, 32'h0,    1'b1, 32'h5002, 2'd0, 1'b1, 1'b0, 4'h0},
    '{32'h0000_0002, 32'h6000, 1'b1, 32'h6000, 1'b0, 32'h0,    2'd0, 1'b0, 1'b1, 4'h1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_idx_i = idx; #0.5; d = reg_rdata_o;
  endtask

  task automatic idle();
    if_valid_i = 0; da_valid_i = 0; da_write_i = 0; step_i = 0; task_sw_i = 0;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset values, R2 mirrors
    for (int i = 0; i < 4; i++) begin rd(3'(i), v); chk("R1 addr", v, 32'h0); end
    rd(6, v); chk("R1 status", v, 32'hFFFF_0FF0);
    rd(7, v); chk("R1 control", v, 32'h0000_0400);
    rd(4, v); chk("R2 mirror status", v, 32'hFFFF_0FF0);
    rd(5, v); chk("R2 mirror control", v, 32'h0000_0400);
    chk("R1 exc", 32'(dbg_exc_o), 0);
    // R2 fixed ones on writes
    wr(6, 32'h0000_F00F); rd(6, v); chk("R2 status write", v, 32'hFFFF_FFFF);
    wr(7, 32'h0); rd(7, v); chk("R2 control write", v, 32'h0000_0400);
    wr(2, 32'hA5A5_0000); rd(2, v); chk("R2 addr write", v, 32'hA5A5_0000);
    wr(2, 32'h0);

    // table: R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      wr(7, TBL[k].ctrl); wr(0, TBL[k].addr); wr(6, 32'h0);
      if_valid_i = TBL[k].iv; if_addr_i = TBL[k].ia;
      da_valid_i = TBL[k].dv; da_addr_i = TBL[k].da;
      da_size_i = TBL[k].ds; da_write_i = TBL[k].dw;
      cyc(); idle();
      chk("R3/R4/R5/R6 exc", 32'(dbg_exc_o), 32'(TBL[k].exc));
      rd(6, v); chk("R4/R5/R6 status", 32'(v[3:0]), 32'(TBL[k].st));
    end

    // R7 disabled match
    wr(7, 32'h0); wr(0, 32'h7000); wr(6, 32'h0);
    if_valid_i = 1; if_addr_i = 32'h7000; cyc(); idle();
    chk("R7 exc", 32'(dbg_exc_o), 0);
    rd(6, v); chk("R7 status", v, 32'hFFFF_0FF0);
    // R8 disabled hit recorded with enabled one, other bits kept
    wr(1, 32'h7000); wr(7, 32'h4); wr(6, 32'h2000);
    if_valid_i = 1; if_addr_i = 32'h7000; cyc(); idle();
    chk("R8 exc", 32'(dbg_exc_o), 1);
    rd(6, v); chk("R8 status", v, 32'hFFFF_2FF3);
    cyc(); chk("R3 pulse ends", 32'(dbg_exc_o), 0);

    // R9 single step
    wr(7, 32'h0); wr(6, 32'h0);
    step_i = 1; if_valid_i = 1; if_addr_i = 32'h7000; cyc(); idle();
    chk("R9 exc", 32'(dbg_exc_o), 0);
    rd(6, v); chk("R9 status", v, 32'hFFFF_4FF3);
    step_i = 1; cyc(); idle();
    rd(6, v); chk("R9 step no hit", v, 32'hFFFF_4FF0);

    // R10 task switch
    wr(7, 32'hFF); task_sw_i = 1; cyc(); idle();
    rd(7, v); chk("R10 clear local", v, 32'h0000_04AA);
    wr(1, 32'h0); wr(0, 32'h1000); wr(7, 32'h1);
    task_sw_i = 1; cyc(); idle();
    if_valid_i = 1; if_addr_i = 32'h1000; cyc(); idle();
    chk("R10 disarmed", 32'(dbg_exc_o), 0);
    task_sw_i = 1; wr(7, 32'h55); idle();
    rd(7, v); chk("R10 write wins", v, 32'h0000_0455);

    // R11 old values used in write cycle
    wr(7, 32'h1); wr(0, 32'h8000);
    if_valid_i = 1; if_addr_i = 32'h8000; wr(0, 32'h9000); idle();
    chk("R11 old addr", 32'(dbg_exc_o), 1);
    if_valid_i = 1; if_addr_i = 32'h9000; cyc(); idle();
    chk("R11 new addr", 32'(dbg_exc_o), 1);
    if_valid_i = 1; if_addr_i = 32'h8000; cyc(); idle();
    chk("R11 old gone", 32'(dbg_exc_o), 0);
    // R8 commit beats software status write
    wr(6, 32'h0000_0002);
    if_valid_i = 1; if_addr_i = 32'h9000; wr(6, 32'h0); idle();
    rd(6, v); chk("R8 commit priority", v, 32'hFFFF_0FF1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule